// File: doc/BRIEF.md
# RTC Time Snapshot Sequencer

This block captures one full calendar time from an external clock device whose registers each hold a single 4-bit digit. It has no direct view of the device. Instead it drives a register-port request interface: a request carrying a read/write flag, a register address and write data, answered by a done strobe that returns the read data. Around each group of accesses it also controls a chip-enable line.

On an accepted command the block first makes sure the device is not updating its counters. Each attempt does three things:

- raises chip enable;
- writes a base value to the control register;
- reads the control register back.

If the busy flag in that read-back is set, chip enable drops for a programmable pause and the attempt repeats, up to a fixed limit. Once the device reports not busy, the block reads a digit pair for each of six fields, then the weekday register. From these it forms binary seconds, minutes, hours, day, month and a four-digit year, and returns them with an error flag.

The command side is a valid/ready pair. `cmd_ready` is high only while the block is idle, and a command is taken on the clock edge where `cmd_valid` and `cmd_ready` are both high. The result side is also valid/ready. `res_valid` stays high, and `res_err` and every time output stay frozen, until the consumer raises `res_ready`, so a slow consumer simply stalls the block before its next command.

Top module: `rtc_snapshot_seq`

## Requirements
- R1: `cmd_ready` is high only when no snapshot is in progress and no result is pending. A result, once `res_valid` is high, holds `res_err` and all time outputs unchanged until the edge where `res_ready` is high; `res_valid` is low in the cycle after that edge.
- R2: Each attempt raises `rp_ce`, then writes `CTRL_BASE` to address `CTRL_ADDR`, then reads `CTRL_ADDR`, and performs no other access before the read-back.
- R3: If bit `BUSY_BIT` of the read-back control value is 1, `rp_ce` goes low for at least `RETRY_WAIT` cycles before the next attempt. After `MAX_TRIES` (default 10) busy attempts the result is returned with `res_err` = 1 and no digit register is read.
- R4: After a not-busy read-back, exactly 13 reads follow, with addresses taken in step order from `READ_MAP` (step i at bits [4i+3:4i]): seconds ones, seconds tens, minutes ones, minutes tens, hours ones, hours tens, day ones, day tens, month ones, month tens, year ones, year tens, weekday.
- R5: Seconds, minutes, hours, day and month each equal ten times the tens digit plus the ones digit.
- R6: The year output equals 1900 plus (two-digit value mod 100), with 100 added when that sum is below 1970. Digits 70..99 therefore give 1970..1999, and 00..69 give 2000..2069.
- R7: `t_wday` equals the 4-bit weekday register value unchanged.
- R8: `rp_ce` is high whenever `rp_req` is high, and is low while a result is presented.
- R9: The time outputs change only when a snapshot completes without error. An errored result leaves them at their previous values.
- R10: After reset `cmd_ready` = 1, `res_valid` = 0, `rp_ce` = 0, `rp_req` = 0, and all time outputs are 0.
- R11: Once `rp_req` rises, it stays high with stable `rp_write`, `rp_addr` and `rp_wdata` until the cycle where `rp_done` is seen, and it is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Snapshot command request |
| cmd_ready | output | 1 | Block idle, command taken when both high |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_err | output | 1 | Device stayed busy for all attempts |
| t_sec | output | FW | Seconds, binary |
| t_min | output | FW | Minutes, binary |
| t_hour | output | FW | Hours, binary |
| t_day | output | FW | Day of month, binary |
| t_mon | output | FW | Month, binary |
| t_year | output | YW | Four-digit year, binary |
| t_wday | output | DW | Weekday register value |
| rp_ce | output | 1 | Device chip enable |
| rp_req | output | 1 | Register access request |
| rp_write | output | 1 | 1 = write, 0 = read |
| rp_addr | output | AW | Register address |
| rp_wdata | output | DW | Write data |
| rp_done | input | 1 | Access complete strobe |
| rp_rdata | input | DW | Read data, valid with `rp_done` |

## Verification
The bench sweeps every two-digit year across the century window. A design with an off-by-one epoch comparison, or one that skips the mod-100 step, would report the wrong century at 69/70 or 00. It also sweeps the number of busy replies from zero up past the attempt limit. Here a miscounted limit shows up as an error at nine attempts, or a spurious extra access at eleven, and a missing pause shows up as a chip-enable gap shorter than `RETRY_WAIT`. The full access log is compared in order, which exposes swapped ones/tens reads or a weekday read out of place. Held results and errored snapshots expose outputs that leak early or get overwritten with stale digits.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  localparam int NUM_FIELDS = 6;
  localparam int NUM_READS  = 2 * NUM_FIELDS + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_CTRL,
    ST_RD_CTRL,
    ST_GAP,
    ST_FETCH,
    ST_COMMIT,
    ST_REPLY
  } seq_state_t;

  // Default register layout: digit pairs in field order, weekday placed
  // between hours and day, so the read order differs from address order.
  function automatic logic [NUM_READS*4-1:0] default_read_map();
    logic [NUM_READS*4-1:0] m;
    logic [3:0] a;
    m = '0;
    for (int i = 0; i < NUM_READS; i++) begin
      if (i == NUM_READS - 1)
        a = 4'd6;
      else if (i < 6)
        a = 4'(i);
      else
        a = 4'(i + 1);
      m[i*4 +: 4] = a;
    end
    return m;
  endfunction

endpackage

// File: rtl/rtc_port_master.sv
module rtc_port_master #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          rp_req,
  output logic          rp_write,
  output logic [AW-1:0] rp_addr,
  output logic [DW-1:0] rp_wdata,
  input  logic          rp_done,
  input  logic [DW-1:0] rp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_req   <= 1'b0;
      rp_write <= 1'b0;
      rp_addr  <= '0;
      rp_wdata <= '0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      if (rp_req) begin
        if (rp_done) begin
          rp_req <= 1'b0;
          done   <= 1'b1;
          rdata  <= rp_rdata;
        end
      end else if (start) begin
        rp_req   <= 1'b1;
        rp_write <= wr;
        rp_addr  <= addr;
        rp_wdata <= wdata;
      end
    end
  end

endmodule

// File: rtl/rtc_gap_timer.sv
module rtc_gap_timer #(
  parameter int WAIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  localparam int CW = $clog2(WAIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= CW'(WAIT);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == CW'(1));

endmodule

// File: rtl/rtc_digit_stage.sv
module rtc_digit_stage #(
  parameter int NF = 6,
  parameter int DW = 4,
  parameter int FW = 8,
  parameter int SW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SW-1:0]    step,
  input  logic [DW-1:0]    din,
  output logic [NF*FW-1:0] fields,
  output logic [DW-1:0]    wday
);

  for (genvar f = 0; f < NF; f++) begin : g_field
    logic [DW-1:0] ones_q;
    logic [FW-1:0] val_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ones_q <= '0;
        val_q  <= '0;
      end else if (load && step == SW'(2*f)) begin
        ones_q <= din;
      end else if (load && step == SW'(2*f + 1)) begin
        val_q <= FW'(din) * FW'(10) + FW'(ones_q);
      end
    end

    assign fields[f*FW +: FW] = val_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      wday <= '0;
    else if (load && step == SW'(2*NF))
      wday <= din;
  end

endmodule

// File: rtl/rtc_year_window.sv
module rtc_year_window #(
  parameter int FW    = 8,
  parameter int YW    = 12,
  parameter int CENT  = 1900,
  parameter int EPOCH = 1970
) (
  input  logic [FW-1:0] raw,
  output logic [YW-1:0] year
);

  logic [FW-1:0] two_dig;
  logic [YW-1:0] base_y;

  always_comb begin
    two_dig = raw % FW'(100);
    base_y  = YW'(CENT) + YW'(two_dig);
    year    = (base_y < YW'(EPOCH)) ? base_y + YW'(100) : base_y;
  end

endmodule

// File: rtl/rtc_snapshot_seq.sv
module rtc_snapshot_seq
  import rtc_snap_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 4,
  parameter int FW         = 8,
  parameter int YW         = 12,
  parameter int MAX_TRIES  = 10,
  parameter int RETRY_WAIT = 8,
  parameter int BUSY_BIT   = 1,
  parameter logic [AW-1:0] CTRL_ADDR = 4'hD,
  parameter logic [DW-1:0] CTRL_BASE = 4'h4,
  parameter logic [NUM_READS*AW-1:0] READ_MAP = default_read_map(),
  parameter int CENT       = 1900,
  parameter int EPOCH      = 1970
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_err,
  output logic [FW-1:0] t_sec,
  output logic [FW-1:0] t_min,
  output logic [FW-1:0] t_hour,
  output logic [FW-1:0] t_day,
  output logic [FW-1:0] t_mon,
  output logic [YW-1:0] t_year,
  output logic [DW-1:0] t_wday,
  output logic          rp_ce,
  output logic          rp_req,
  output logic          rp_write,
  output logic [AW-1:0] rp_addr,
  output logic [DW-1:0] rp_wdata,
  input  logic          rp_done,
  input  logic [DW-1:0] rp_rdata
);

  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam int STEP_W = $clog2(NUM_READS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_READS - 1);

  seq_state_t        state;
  logic [TRY_W-1:0]  tries;
  logic [STEP_W-1:0] step;
  logic              inflight;

  logic              pm_start, pm_wr, pm_done;
  logic [AW-1:0]     pm_addr;
  logic [DW-1:0]     pm_rdata;
  logic              gap_start, gap_expired;
  logic              busy_seen, last_try, access_state;
  logic [NUM_FIELDS*FW-1:0] stage_fields;
  logic [DW-1:0]     stage_wday;
  logic [YW-1:0]     year_full;

  // ---------------------------------------------------------------- access
  assign access_state = (state == ST_WR_CTRL) || (state == ST_RD_CTRL) ||
                        (state == ST_FETCH);
  assign pm_start  = access_state && !inflight;
  assign pm_wr     = (state == ST_WR_CTRL);
  assign pm_addr   = (state == ST_FETCH) ? READ_MAP[step*AW +: AW] : CTRL_ADDR;
  assign busy_seen = pm_rdata[BUSY_BIT];
  assign last_try  = (tries == TRY_W'(MAX_TRIES - 1));
  assign gap_start = (state == ST_RD_CTRL) && pm_done && busy_seen && !last_try;

  rtc_port_master #(.AW(AW), .DW(DW)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (pm_start),
    .wr       (pm_wr),
    .addr     (pm_addr),
    .wdata    (CTRL_BASE),
    .done     (pm_done),
    .rdata    (pm_rdata),
    .rp_req   (rp_req),
    .rp_write (rp_write),
    .rp_addr  (rp_addr),
    .rp_wdata (rp_wdata),
    .rp_done  (rp_done),
    .rp_rdata (rp_rdata)
  );

  rtc_gap_timer #(.WAIT(RETRY_WAIT)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (gap_start),
    .expired (gap_expired)
  );

  rtc_digit_stage #(.NF(NUM_FIELDS), .DW(DW), .FW(FW), .SW(STEP_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (pm_done && state == ST_FETCH),
    .step   (step),
    .din    (pm_rdata),
    .fields (stage_fields),
    .wday   (stage_wday)
  );

  rtc_year_window #(.FW(FW), .YW(YW), .CENT(CENT), .EPOCH(EPOCH)) u_year (
    .raw  (stage_fields[5*FW +: FW]),
    .year (year_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      inflight <= 1'b0;
    else if (pm_start)
      inflight <= 1'b1;
    else if (pm_done)
      inflight <= 1'b0;
  end

  // ------------------------------------------------------------ sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rp_ce   <= 1'b0;
      tries   <= '0;
      step    <= '0;
      res_err <= 1'b0;
      t_sec   <= '0;
      t_min   <= '0;
      t_hour  <= '0;
      t_day   <= '0;
      t_mon   <= '0;
      t_year  <= '0;
      t_wday  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            rp_ce <= 1'b1;
            tries <= '0;
            state <= ST_WR_CTRL;
          end
        end
        ST_WR_CTRL: begin
          if (pm_done) state <= ST_RD_CTRL;
        end
        ST_RD_CTRL: begin
          if (pm_done) begin
            if (busy_seen) begin
              rp_ce <= 1'b0;
              if (last_try) begin
                res_err <= 1'b1;
                state   <= ST_REPLY;
              end else begin
                tries <= tries + TRY_W'(1);
                state <= ST_GAP;
              end
            end else begin
              step  <= '0;
              state <= ST_FETCH;
            end
          end
        end
        ST_GAP: begin
          if (gap_expired) begin
            rp_ce <= 1'b1;
            state <= ST_WR_CTRL;
          end
        end
        ST_FETCH: begin
          if (pm_done) begin
            if (step == LAST_STEP) begin
              rp_ce <= 1'b0;
              state <= ST_COMMIT;
            end else begin
              step <= step + STEP_W'(1);
            end
          end
        end
        ST_COMMIT: begin
          t_sec   <= stage_fields[0*FW +: FW];
          t_min   <= stage_fields[1*FW +: FW];
          t_hour  <= stage_fields[2*FW +: FW];
          t_day   <= stage_fields[3*FW +: FW];
          t_mon   <= stage_fields[4*FW +: FW];
          t_year  <= year_full;
          t_wday  <= stage_wday;
          res_err <= 1'b0;
          state   <= ST_REPLY;
        end
        ST_REPLY: begin
          if (res_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign res_valid = (state == ST_REPLY);

endmodule

// File: rtl/rtc_snapshot_seq_chk.sv
module rtc_snapshot_seq_chk #(
  parameter int AW = 4,
  parameter int DW = 4,
  parameter int FW = 8,
  parameter int YW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic          res_err,
  input logic [FW-1:0] t_sec,
  input logic [FW-1:0] t_min,
  input logic [YW-1:0] t_year,
  input logic [DW-1:0] t_wday,
  input logic          rp_ce,
  input logic          rp_req,
  input logic          rp_write,
  input logic [AW-1:0] rp_addr,
  input logic [DW-1:0] rp_wdata,
  input logic          rp_done
);

  a_r1_no_cmd_while_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);

  a_r1_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_err) &&
      $stable(t_sec) && $stable(t_min) && $stable(t_year) && $stable(t_wday)));

  a_r8_ce_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req |-> rp_ce);

  a_r8_ce_low_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !rp_ce);

  a_r9_update_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    (t_sec != $past(t_sec) || t_min != $past(t_min) ||
     t_year != $past(t_year) || t_wday != $past(t_wday)) |-> (res_valid && !res_err));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_req && !rp_done) |=> (rp_req && $stable(rp_write) &&
      $stable(rp_addr) && $stable(rp_wdata)));

  a_r11_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_req && rp_done) |=> !rp_req);

endmodule

bind rtc_snapshot_seq rtc_snapshot_seq_chk #(.AW(AW), .DW(DW), .FW(FW), .YW(YW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_err   (res_err),
  .t_sec     (t_sec),
  .t_min     (t_min),
  .t_year    (t_year),
  .t_wday    (t_wday),
  .rp_ce     (rp_ce),
  .rp_req    (rp_req),
  .rp_write  (rp_write),
  .rp_addr   (rp_addr),
  .rp_wdata  (rp_wdata),
  .rp_done   (rp_done)
);

// File: tb/test_rtc_snapshot_seq.sv
`timescale 1ns/1ps
module test_rtc_snapshot_seq;

  localparam int AW = 4, DW = 4, FW = 8, YW = 12;
  localparam int TRIES = 10, GAP = 8, BUSYB = 1;
  localparam logic [3:0] CADDR = 4'hD, CBASE = 4'h4;
  localparam int NRD = 13;

  // read order addresses: sec1 0, sec10 1, min1 2, min10 3, hr1 4, hr10 5,
  // day1 7, day10 8, mon1 9, mon10 10, yr1 11, yr10 12, wday 6
  function automatic int order_addr(input int i);
    if (i == NRD - 1) return 6;
    if (i < 6) return i;
    return i + 1;
  endfunction

  function automatic logic [NRD*4-1:0] build_map();
    logic [NRD*4-1:0] m;
    m = '0;
    for (int i = 0; i < NRD; i++) m[i*4 +: 4] = 4'(order_addr(i));
    return m;
  endfunction

  localparam logic [NRD*4-1:0] MAP = build_map();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, res_ready = 1'b0;
  logic cmd_ready, res_valid, res_err;
  logic [FW-1:0] t_sec, t_min, t_hour, t_day, t_mon;
  logic [YW-1:0] t_year;
  logic [DW-1:0] t_wday;
  logic rp_ce, rp_req, rp_write;
  logic [AW-1:0] rp_addr;
  logic [DW-1:0] rp_wdata;
  logic rp_done = 1'b0;
  logic [DW-1:0] rp_rdata = '0;

  always #2.5 clk = ~clk;

  rtc_snapshot_seq #(
    .AW(AW), .DW(DW), .FW(FW), .YW(YW), .MAX_TRIES(TRIES), .RETRY_WAIT(GAP),
    .BUSY_BIT(BUSYB), .CTRL_ADDR(CADDR), .CTRL_BASE(CBASE), .READ_MAP(MAP)
  ) i_rtc_snapshot_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_err(res_err),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_day(t_day), .t_mon(t_mon),
    .t_year(t_year), .t_wday(t_wday), .rp_ce(rp_ce), .rp_req(rp_req),
    .rp_write(rp_write), .rp_addr(rp_addr), .rp_wdata(rp_wdata),
    .rp_done(rp_done), .rp_rdata(rp_rdata)
  );

  int n_checks = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------------------------------------------------- device model
  logic [3:0] regs [16];
  int busy_n = 0, lat = 0, wcnt = 0;
  int ctrl_writes = 0, wdata_bad = 0, proto_bad = 0, ce_bad = 0;
  int log_n = 0;
  logic [4:0] log_q [64];
  logic [3:0] cap_addr;
  logic cap_wr;

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    forever begin
      @(negedge clk);
      if (rp_done) begin
        rp_done = 1'b0;
      end else if (rp_req) begin
        if (wcnt == 0) begin
          cap_addr = rp_addr;
          cap_wr = rp_write;
        end else if (rp_addr != cap_addr || rp_write != cap_wr) begin
          proto_bad++;
        end
        if (!rp_ce) ce_bad++;
        if (wcnt < lat) begin
          wcnt++;
        end else begin
          wcnt = 0;
          if (log_n < 64) log_q[log_n] = {rp_write, rp_addr};
          log_n++;
          if (rp_write) begin
            if (rp_addr == CADDR) begin
              ctrl_writes++;
              if (rp_wdata != CBASE) wdata_bad++;
            end else begin
              regs[rp_addr] = rp_wdata;
            end
          end else if (rp_addr == CADDR) begin
            rp_rdata = (ctrl_writes <= busy_n) ? (CBASE | 4'(1 << BUSYB)) : CBASE;
          end else begin
            rp_rdata = regs[rp_addr];
          end
          rp_done = 1'b1;
        end
      end else if (wcnt != 0) begin
        proto_bad++;
        wcnt = 0;
      end
    end
  end

  // ------------------------------------------------- chip-enable gap monitor
  int rises = 0, low_run = 0, min_gap = 9999;
  logic ce_prev = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rp_ce && !ce_prev) begin
        rises++;
        if (rises > 1 && low_run < min_gap) min_gap = low_run;
        low_run = 0;
      end else if (!rp_ce) begin
        low_run++;
      end
      ce_prev = rp_ce;
    end
  end

  // ------------------------------------------------------------ watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  int p_sec = 0, p_min = 0, p_hour = 0, p_day = 0, p_mon = 0, p_year = 0, p_wday = 0;

  task automatic run_txn(input int bn, input int lt, input int s, input int mi,
                         input int h, input int d, input int mo, input int y2,
                         input int wd);
    int attempts, exp_year, mism, hs, hy;
    bit exp_err;
    regs[0] = 4'(s % 10);  regs[1] = 4'(s / 10);
    regs[2] = 4'(mi % 10); regs[3] = 4'(mi / 10);
    regs[4] = 4'(h % 10);  regs[5] = 4'(h / 10);
    regs[7] = 4'(d % 10);  regs[8] = 4'(d / 10);
    regs[9] = 4'(mo % 10); regs[10] = 4'(mo / 10);
    regs[11] = 4'(y2 % 10); regs[12] = 4'(y2 / 10);
    regs[6] = 4'(wd);
    busy_n = bn; lat = lt; ctrl_writes = 0; log_n = 0;
    wdata_bad = 0; proto_bad = 0; ce_bad = 0; rises = 0; min_gap = 9999;
    exp_err = (bn >= TRIES);
    attempts = exp_err ? TRIES : bn + 1;

    @(negedge clk);
    cmd_valid = 1'b1;
    @(posedge clk);
    while (!cmd_ready) @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1", "cmd_ready while busy", int'(cmd_ready), 0);
    while (!res_valid) @(negedge clk);

    chk(!cmd_ready, "R1", "cmd_ready with result", int'(cmd_ready), 0);
    chk(!rp_ce, "R8", "ce at result", int'(rp_ce), 0);
    chk(ce_bad == 0, "R8", "access with ce low", ce_bad, 0);
    chk(proto_bad == 0, "R11", "request protocol", proto_bad, 0);
    chk(wdata_bad == 0, "R2", "control write data", wdata_bad, 0);
    chk(res_err == exp_err, "R3", "error flag", int'(res_err), int'(exp_err));
    chk(ctrl_writes == attempts, "R3", "attempt count", ctrl_writes, attempts);
    if (bn > 0)
      chk(min_gap >= GAP, "R3", "ce gap between attempts", min_gap, GAP);

    // access log: W/R control per attempt, then the digit reads in order
    mism = 0;
    for (int a = 0; a < attempts; a++) begin
      if (log_q[2*a] != {1'b1, CADDR}) mism++;
      if (log_q[2*a+1] != {1'b0, CADDR}) mism++;
    end
    if (!exp_err)
      for (int i = 0; i < NRD; i++)
        if (log_q[2*attempts + i] != {1'b0, 4'(order_addr(i))}) mism++;
    chk(mism == 0 && log_n == 2*attempts + (exp_err ? 0 : NRD),
        "R4", "access order mismatches", mism, 0);

    if (!exp_err) begin
      exp_year = 1900 + (y2 % 100);
      if (exp_year < 1970) exp_year += 100;
      chk(t_sec == FW'(s) && t_min == FW'(mi) && t_hour == FW'(h),
          "R5", "sec/min/hour", int'(t_sec)*10000 + int'(t_min)*100 + int'(t_hour),
          s*10000 + mi*100 + h);
      chk(t_day == FW'(d) && t_mon == FW'(mo), "R5", "day/month",
          int'(t_day)*100 + int'(t_mon), d*100 + mo);
      chk(int'(t_year) == exp_year, "R6", "year", int'(t_year), exp_year);
      chk(int'(t_wday) == wd, "R7", "weekday", int'(t_wday), wd);
      p_sec = s; p_min = mi; p_hour = h; p_day = d; p_mon = mo;
      p_year = exp_year; p_wday = wd;
    end else begin
      chk(int'(t_sec) == p_sec && int'(t_min) == p_min && int'(t_hour) == p_hour &&
          int'(t_day) == p_day && int'(t_mon) == p_mon && int'(t_wday) == p_wday,
          "R9", "fields kept on error", int'(t_sec), p_sec);
      chk(int'(t_year) == p_year, "R9", "year kept on error", int'(t_year), p_year);
    end

    // hold the result under back-pressure
    hs = int'(t_sec); hy = int'(t_year);
    repeat (3) begin
      @(negedge clk);
      chk(res_valid && int'(t_sec) == hs && int'(t_year) == hy &&
          res_err == exp_err, "R1", "result held", int'(t_sec), hs);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && cmd_ready, "R1", "result released", int'(res_valid), 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready && !res_valid && !rp_ce && !rp_req, "R10", "control outputs",
        int'({cmd_ready, res_valid, rp_ce, rp_req}), 8);
    chk(t_sec == '0 && t_min == '0 && t_hour == '0 && t_day == '0 &&
        t_mon == '0 && t_year == '0 && t_wday == '0, "R10", "time outputs",
        int'(t_year), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !rp_req, "R10", "idle after reset", int'(cmd_ready), 1);

    // busy-count sweep across the attempt limit
    for (int b = 0; b <= 11; b++)
      run_txn(b, b % 3, 37, 59, 23, 31, 12, 99, 6);

    // full two-digit year sweep with varied fields
    for (int y = 0; y < 100; y++)
      run_txn(y % 3, y % 4, (y*7) % 60, (y*13) % 60, (y*5) % 24,
              1 + y % 31, 1 + y % 12, y, y % 7);

    // error after varied data keeps the last good snapshot
    run_txn(TRIES, 1, 1, 2, 3, 4, 5, 6, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule